// File: doc/BRIEF.md
# Compressed-Aware Instruction Fetch Cache

This block is a first-level instruction cache for a core that issues a mix of 16-bit and 32-bit instructions. It holds 2 KB of code in two ways of 64 sets, each line 128 bits wide. The core presents a halfword-aligned fetch address together with a request. In the same cycle the cache returns the instruction found there, a flag that marks it as compressed, and a hit indication. The instruction length comes from the two lowest bits of the first halfword. A 32-bit instruction may begin on any halfword, including the last halfword of a line. In that case its upper half sits in the following line, and that line is looked up in the same cycle.

On a miss the cache holds the core in a stall and asks the lower level for the missing line. It names the line by its line-aligned address. The lower level answers with a one-cycle data pulse while the request is still high, and the line is written into a way picked by the replacement rule. If both the fetch line and the following line are missing, the fetch line is requested first. The core holds its request and address steady until it sees a hit.

Top module: `ic_fetch_cache`

## Requirements
- R1: After reset every line is invalid, so the first request to any address misses and asks for a refill.
- R2: While the request is high and the line holding the first halfword is absent, the cache requests a refill with `refill_addr[18:4]` equal to `fetch_addr[18:4]` and `refill_addr[3:0]` zero. A line delivered with `refill_valid` is written, so the same line is not requested again.
- R3: When `fetch_instr[1:0]` is 2'b11 the output is a 32-bit instruction and `fetch_is_comp` is 0. Any other value marks a compressed instruction: `fetch_is_comp` is 1 and `fetch_instr[31:16]` is zero.
- R4: A 32-bit instruction that starts on halfword slot p (bits [3:1]) below 7 takes its lower half from slot p and its upper half from slot p+1 of the same line. Slot s of a line is `line[16*s+15:16*s]`.
- R5: A 32-bit instruction that starts on slot 7 takes its upper half from slot 0 of the following line. If that line is absent, the cache stalls and requests it, with `refill_addr[18:4]` equal to `fetch_addr[18:4]+1`.
- R6: The following line of a line in set 63 lies in set 0, with its tag one higher; the address bits [18:4] are incremented as one 15-bit value.
- R7: A refill goes to way 0 when both ways of the set are invalid, to the invalid way when only one is valid, and to the least recently used way when both are valid.
- R8: Each hit marks the way that supplied the fetch line as most recently used. A straddling hit also marks the way that supplied the following line in its own set. A refill does not change the recency state.
- R9: `fetch_hit` is high only while the request is high and every line the instruction needs is present. `fetch_stall` equals the request with no hit, and with no request `fetch_hit`, `fetch_stall` and `refill_req` are all low.
- R10: `refill_valid` has no effect while `refill_req` is low.
- R11: A compressed instruction in slot 7 needs only its own line; the following line is neither required nor requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | Core fetch request, held until hit |
| fetch_addr | input | 19 | Halfword-aligned fetch address |
| fetch_instr | output | 32 | Instruction at the fetch address |
| fetch_is_comp | output | 1 | High when the instruction is 16 bits |
| fetch_hit | output | 1 | Instruction valid this cycle |
| fetch_stall | output | 1 | Request pending without a hit |
| refill_req | output | 1 | Refill request to the lower level |
| refill_addr | output | 19 | Line-aligned address of the requested line |
| refill_valid | input | 1 | Refill data present this cycle |
| refill_data | input | 128 | Refill line, slot 0 in the low bits |

## Verification
The hardest case is a straddling 32-bit instruction whose following line is already present. Its only lasting effect is the recency update in the following line's set, and nothing at the ports shows that update directly. The stimulus first fills that set with two lines, leaving the later one most recent. It then issues a straddling fetch from the set below, which touches the older line through the following-line path. A new line mapped to the same set must then evict the other line, and a refetch of the touched line must hit with no refill request. The stimulus reaches the wrap from set 63 to set 0 with a straddle at the top set, and reaches the refill-ignored case with data pulses sent while no request is pending.

// File: rtl/ic_pkg.sv
package ic_pkg;
    localparam int ADDR_W      = 19;
    localparam int TAG_W       = 9;
    localparam int IDX_W       = 6;
    localparam int OFF_W       = ADDR_W - TAG_W - IDX_W;
    localparam int LINE_W      = 128;
    localparam int HW_W        = 16;
    localparam int INSTR_W     = 2 * HW_W;
    localparam int WAYS        = 2;
    localparam int SETS        = 1 << IDX_W;
    localparam int HW_PER_LINE = LINE_W / HW_W;
    localparam int POS_W       = $clog2(HW_PER_LINE);
    localparam int LADDR_W     = TAG_W + IDX_W;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [IDX_W-1:0] idx;
    } line_addr_t;

    typedef struct packed {
        logic               hit;
        logic               way;
        logic [LINE_W-1:0]  data;
    } lookup_t;

    function automatic line_addr_t following_line(input line_addr_t la);
        return line_addr_t'(la + LADDR_W'(1));
    endfunction

    function automatic logic is_full_len(input logic [HW_W-1:0] hw);
        return hw[1:0] == 2'b11;
    endfunction
endpackage

// File: rtl/ic_way_store.sv
module ic_way_store
    import ic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  line_addr_t        rd_a,
    input  line_addr_t        rd_b,
    input  logic              wr_en,
    input  line_addr_t        wr_line,
    input  logic [LINE_W-1:0] wr_data,
    output logic              hit_a,
    output logic              hit_b,
    output logic [LINE_W-1:0] data_a,
    output logic [LINE_W-1:0] data_b,
    output logic              wr_set_valid
);
    logic [SETS-1:0]   valid_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [LINE_W-1:0] data_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_line.idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_line.idx]  <= wr_line.tag;
            data_q[wr_line.idx] <= wr_data;
        end
    end

    assign hit_a        = valid_q[rd_a.idx] && (tag_q[rd_a.idx] == rd_a.tag);
    assign hit_b        = valid_q[rd_b.idx] && (tag_q[rd_b.idx] == rd_b.tag);
    assign data_a       = data_q[rd_a.idx];
    assign data_b       = data_q[rd_b.idx];
    assign wr_set_valid = valid_q[wr_line.idx];
endmodule

// File: rtl/ic_lru.sv
module ic_lru
    import ic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             touch_a,
    input  logic [IDX_W-1:0] idx_a,
    input  logic             way_a,
    input  logic             touch_b,
    input  logic [IDX_W-1:0] idx_b,
    input  logic             way_b,
    input  logic [IDX_W-1:0] vic_idx,
    input  logic [WAYS-1:0]  vic_valid,
    output logic             vic_way
);
    // bit set: way 1 is the next victim of that set
    logic [SETS-1:0] evict_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            evict_q <= '0;
        end else begin
            if (touch_a) evict_q[idx_a] <= ~way_a;
            if (touch_b) evict_q[idx_b] <= ~way_b;
        end
    end

    always_comb begin
        if (!vic_valid[0])      vic_way = 1'b0;
        else if (!vic_valid[1]) vic_way = 1'b1;
        else                    vic_way = evict_q[vic_idx];
    end
endmodule

// File: rtl/ic_align.sv
module ic_align
    import ic_pkg::*;
(
    input  logic [LINE_W-1:0]  cur_line,
    input  logic [LINE_W-1:0]  nxt_line,
    input  logic [POS_W-1:0]   slot,
    output logic [INSTR_W-1:0] instr,
    output logic               is_comp,
    output logic               straddle
);
    logic [HW_W-1:0]  lo_hw;
    logic [HW_W-1:0]  hi_hw;
    logic [POS_W-1:0] slot_up;
    logic             last_slot;

    assign slot_up   = slot + POS_W'(1);
    assign last_slot = (slot == POS_W'(HW_PER_LINE - 1));
    assign lo_hw     = cur_line[slot*HW_W +: HW_W];
    assign hi_hw     = last_slot ? nxt_line[HW_W-1:0] : cur_line[slot_up*HW_W +: HW_W];
    assign is_comp   = !is_full_len(lo_hw);
    assign straddle  = !is_comp && last_slot;
    assign instr     = is_comp ? {{HW_W{1'b0}}, lo_hw} : {hi_hw, lo_hw};
endmodule

// File: rtl/ic_fetch_cache.sv
module ic_fetch_cache
    import ic_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               fetch_req,
    input  logic [ADDR_W-1:0]  fetch_addr,
    output logic [INSTR_W-1:0] fetch_instr,
    output logic               fetch_is_comp,
    output logic               fetch_hit,
    output logic               fetch_stall,
    output logic               refill_req,
    output logic [ADDR_W-1:0]  refill_addr,
    input  logic               refill_valid,
    input  logic [LINE_W-1:0]  refill_data
);
    line_addr_t cur_la, nxt_la, fill_la;
    lookup_t    cur_lk, nxt_lk;
    logic [WAYS-1:0]   hit_a, hit_b, set_valid;
    logic [LINE_W-1:0] data_a [WAYS];
    logic [LINE_W-1:0] data_b [WAYS];
    logic straddle, fill_en, vic_way;
    logic unused_hw_bit;

    assign unused_hw_bit = fetch_addr[0];
    assign cur_la = line_addr_t'(fetch_addr[ADDR_W-1:OFF_W]);
    assign nxt_la = following_line(cur_la);

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            ic_way_store u_store (
                .clk          (clk),
                .rst          (rst),
                .rd_a         (cur_la),
                .rd_b         (nxt_la),
                .wr_en        (fill_en && (vic_way == w[0])),
                .wr_line      (fill_la),
                .wr_data      (refill_data),
                .hit_a        (hit_a[w]),
                .hit_b        (hit_b[w]),
                .data_a       (data_a[w]),
                .data_b       (data_b[w]),
                .wr_set_valid (set_valid[w])
            );
        end
    endgenerate

    always_comb begin
        cur_lk.hit  = |hit_a;
        cur_lk.way  = hit_a[1];
        cur_lk.data = data_a[hit_a[1]];
        nxt_lk.hit  = |hit_b;
        nxt_lk.way  = hit_b[1];
        nxt_lk.data = data_b[hit_b[1]];
    end

    ic_align u_align (
        .cur_line (cur_lk.data),
        .nxt_line (nxt_lk.data),
        .slot     (fetch_addr[OFF_W-1:1]),
        .instr    (fetch_instr),
        .is_comp  (fetch_is_comp),
        .straddle (straddle)
    );

    assign fetch_hit   = fetch_req && cur_lk.hit && (!straddle || nxt_lk.hit);
    assign fetch_stall = fetch_req && !fetch_hit;
    assign refill_req  = fetch_stall;
    assign fill_la     = cur_lk.hit ? nxt_la : cur_la;
    assign refill_addr = {fill_la, {OFF_W{1'b0}}};
    assign fill_en     = refill_req && refill_valid;

    ic_lru u_lru (
        .clk       (clk),
        .rst       (rst),
        .touch_a   (fetch_hit),
        .idx_a     (cur_la.idx),
        .way_a     (cur_lk.way),
        .touch_b   (fetch_hit && straddle),
        .idx_b     (nxt_la.idx),
        .way_b     (nxt_lk.way),
        .vic_idx   (fill_la.idx),
        .vic_valid (set_valid),
        .vic_way   (vic_way)
    );
endmodule

// File: rtl/ic_fetch_cache_chk.sv
module ic_fetch_cache_chk
    import ic_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               fetch_req,
    input logic [ADDR_W-1:0]  fetch_addr,
    input logic [INSTR_W-1:0] fetch_instr,
    input logic               fetch_is_comp,
    input logic               fetch_hit,
    input logic               fetch_stall,
    input logic               refill_req,
    input logic [ADDR_W-1:0]  refill_addr,
    input logic               refill_valid
);
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !fetch_req |-> (!fetch_hit && !fetch_stall && !refill_req));

    p_stall_no_hit_r9: assert property (@(posedge clk) disable iff (rst)
        fetch_stall |-> !fetch_hit);

    p_len_flag_r3: assert property (@(posedge clk) disable iff (rst)
        fetch_hit |-> (fetch_is_comp == (fetch_instr[1:0] != 2'b11)));

    p_comp_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (fetch_hit && fetch_is_comp) |-> (fetch_instr[31:16] == 16'h0));

    p_refill_aligned_r2: assert property (@(posedge clk) disable iff (rst)
        refill_req |-> (refill_addr[OFF_W-1:0] == '0));

    // R5, R6: only the fetch line or its successor is ever requested
    p_refill_target_r5: assert property (@(posedge clk) disable iff (rst)
        refill_req |-> ((refill_addr[ADDR_W-1:OFF_W] == fetch_addr[ADDR_W-1:OFF_W]) ||
                        (refill_addr[ADDR_W-1:OFF_W] == fetch_addr[ADDR_W-1:OFF_W] + LADDR_W'(1))));

    p_fill_sticks_r2: assert property (@(posedge clk) disable iff (rst)
        (refill_req && refill_valid) |=>
            (!(fetch_req && $stable(fetch_addr)) || !refill_req ||
             (refill_addr != $past(refill_addr))));
endmodule

bind ic_fetch_cache ic_fetch_cache_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .fetch_req     (fetch_req),
    .fetch_addr    (fetch_addr),
    .fetch_instr   (fetch_instr),
    .fetch_is_comp (fetch_is_comp),
    .fetch_hit     (fetch_hit),
    .fetch_stall   (fetch_stall),
    .refill_req    (refill_req),
    .refill_addr   (refill_addr),
    .refill_valid  (refill_valid)
);

// File: tb/ic_fetch_cache_tb.sv
`timescale 1ns/1ps
module ic_fetch_cache_tb;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         fetch_req = 1'b0;
    logic [18:0]  fetch_addr = '0;
    logic [31:0]  fetch_instr;
    logic         fetch_is_comp, fetch_hit, fetch_stall, refill_req;
    logic [18:0]  refill_addr;
    logic         refill_valid = 1'b0;
    logic [127:0] refill_data = '0;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [31:0] exp_instr_q[$];
    logic        exp_comp_q[$];
    string       exp_tag_q[$];
    logic [18:0] rf_addr_q[$];
    string       rf_tag_q[$];

    logic [8:0] m_tag [2][64];
    logic       m_val [2][64];
    logic       m_evict [64];

    always #2 clk = ~clk;

    ic_fetch_cache u_dut (
        .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_instr(fetch_instr), .fetch_is_comp(fetch_is_comp), .fetch_hit(fetch_hit),
        .fetch_stall(fetch_stall), .refill_req(refill_req), .refill_addr(refill_addr),
        .refill_valid(refill_valid), .refill_data(refill_data)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory content: 32-bit starts at slots 0,3,5 and at slot 7 when addr bit 10 is 0
    function automatic logic [15:0] hw(input logic [18:0] a);
        logic [2:0] p;
        logic       full;
        p = a[3:1];
        full = (p == 3'd0) || (p == 3'd3) || (p == 3'd5) || (p == 3'd7 && !a[10]);
        hw[15:2] = {a[18:10] ^ {a[9], 8'h0}, a[8:4]} ^ {a[3:1], 11'h0};
        hw[1:0]  = full ? 2'b11 : {1'b0, a[1]};
    endfunction

    function automatic logic [127:0] line_data(input logic [14:0] l);
        logic [127:0] d;
        for (int p = 0; p < 8; p++) d[p*16 +: 16] = hw({l, p[2:0], 1'b0});
        return d;
    endfunction

    function automatic bit m_lookup(input logic [14:0] l, output int w);
        w = 0;
        for (int i = 0; i < 2; i++)
            if (m_val[i][l[5:0]] && m_tag[i][l[5:0]] == l[14:6]) begin w = i; return 1; end
        return 0;
    endfunction

    function automatic void m_fill(input logic [14:0] l);
        int v;
        if (!m_val[0][l[5:0]])      v = 0;
        else if (!m_val[1][l[5:0]]) v = 1;
        else                        v = int'(m_evict[l[5:0]]);
        m_val[v][l[5:0]] = 1;
        m_tag[v][l[5:0]] = l[14:6];
    endfunction

    function automatic void need_line(input logic [14:0] l, input string tag, inout int n);
        int w;
        if (!m_lookup(l, w)) begin
            rf_addr_q.push_back({l, 4'h0});
            rf_tag_q.push_back(tag);
            m_fill(l);
            n++;
        end
        void'(m_lookup(l, w));
        m_evict[l[5:0]] = (w == 0);
    endfunction

    task automatic fetch(input logic [18:0] a, input string tag);
        logic [14:0] pl, nl;
        logic [15:0] lo, hi;
        int n = 0;
        bit first = 1;
        bit fin = 0;
        bit rq;
        logic [18:0] ra;
        pl = a[18:4];
        nl = pl + 15'd1;
        need_line(pl, tag, n);
        lo = hw(a);
        if (lo[1:0] == 2'b11) begin
            if (a[3:1] == 3'd7) begin
                hi = hw({nl, 4'h0});
                need_line(nl, tag, n);
            end else begin
                hi = hw(a + 19'd2);
            end
            exp_instr_q.push_back({hi, lo});
            exp_comp_q.push_back(1'b0);
        end else begin
            exp_instr_q.push_back({16'h0, lo});
            exp_comp_q.push_back(1'b1);
        end
        exp_tag_q.push_back(tag);
        @(negedge clk); #1;
        fetch_req = 1'b1;
        fetch_addr = a;
        while (!fin) begin
            @(negedge clk);
            if (first) begin
                check(fetch_stall == (n > 0), {tag, " R9 stall on first cycle"}, 64'(fetch_stall), 64'(n > 0));
                first = 0;
            end
            if (fetch_hit) begin
                fin = 1;
                @(posedge clk); #1;
                fetch_req = 1'b0;
                refill_valid = 1'b0;
            end else begin
                rq = refill_req;
                ra = refill_addr;
                #1;
                refill_valid = rq;
                refill_data = line_data(ra[18:4]);
            end
        end
        check(rf_addr_q.size() == 0, {tag, " R2 all expected refills requested"}, 64'(rf_addr_q.size()), 64'd0);
        rf_addr_q.delete();
        rf_tag_q.delete();
    endtask

    function automatic logic [18:0] mk(input logic [8:0] t, input logic [5:0] s, input logic [2:0] p);
        return {t, s, p, 1'b0};
    endfunction

    always @(negedge clk) begin
        if (!rst && fetch_req && fetch_hit) begin
            if (exp_instr_q.size() == 0) begin
                check(0, "R9 unexpected hit", 64'(fetch_instr), 64'd0);
            end else begin
                logic [31:0] ei;
                logic ec;
                string et;
                ei = exp_instr_q.pop_front();
                ec = exp_comp_q.pop_front();
                et = exp_tag_q.pop_front();
                check(fetch_instr == ei, {et, " instruction"}, 64'(fetch_instr), 64'(ei));
                check(fetch_is_comp == ec, {et, " R3 compressed flag"}, 64'(fetch_is_comp), 64'(ec));
            end
        end
        if (!rst && refill_req) begin
            if (rf_addr_q.size() == 0) begin
                check(0, "R2 unexpected refill request", 64'(refill_addr), 64'd0);
            end else begin
                logic [18:0] ea;
                string et;
                ea = rf_addr_q.pop_front();
                et = rf_tag_q.pop_front();
                check(refill_addr == ea, {et, " refill address"}, 64'(refill_addr), 64'(ea));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int w = 0; w < 2; w++)
            for (int s = 0; s < 64; s++) begin m_val[w][s] = 0; m_tag[w][s] = '0; end
        for (int s = 0; s < 64; s++) m_evict[s] = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1, R9: idle after reset
        check(!fetch_hit && !fetch_stall && !refill_req, "R1 R9 idle outputs after reset",
              64'({fetch_hit, fetch_stall, refill_req}), 64'd0);

        fetch(mk(9'd0, 6'd0, 3'd0), "R1 R2 R3 cold miss aligned 32-bit");
        fetch(mk(9'd0, 6'd0, 3'd1), "R3 compressed hit");
        fetch(mk(9'd0, 6'd0, 3'd2), "R3 compressed hit slot 2");
        fetch(mk(9'd0, 6'd0, 3'd3), "R4 misaligned 32-bit");
        fetch(mk(9'd0, 6'd0, 3'd7), "R5 straddle next line miss");
        fetch(mk(9'd0, 6'd0, 3'd7), "R5 straddle both present");
        fetch(mk(9'd2, 6'd63, 3'd7), "R6 straddle wrap set 63 to 0");
        fetch(mk(9'd1, 6'd5, 3'd7), "R11 compressed in last slot");

        // R7, R8: victim choice in set 10
        fetch(mk(9'd0, 6'd10, 3'd0), "R7 fill way 0");
        fetch(mk(9'd1, 6'd10, 3'd0), "R7 fill other invalid way");
        fetch(mk(9'd0, 6'd10, 3'd1), "R8 hit marks way 0 recent");
        fetch(mk(9'd2, 6'd10, 3'd0), "R7 R8 evict least recent");
        fetch(mk(9'd0, 6'd10, 3'd2), "R8 recent line kept");
        fetch(mk(9'd1, 6'd10, 3'd1), "R7 evicted line refetched");

        // R8: straddle updates recency of the following line's set
        fetch(mk(9'd4, 6'd20, 3'd0), "R8 fill set 20 way 0");
        fetch(mk(9'd5, 6'd20, 3'd0), "R8 fill set 20 way 1");
        fetch(mk(9'd4, 6'd19, 3'd7), "R8 straddle touches set 20");
        fetch(mk(9'd6, 6'd20, 3'd0), "R8 new line evicts untouched way");
        fetch(mk(9'd4, 6'd20, 3'd1), "R8 touched line still present");

        // R10: refill data without request
        @(negedge clk); #1;
        refill_valid = 1'b1;
        refill_data = line_data({9'd7, 6'd40});
        @(negedge clk);
        check(!refill_req && !fetch_hit, "R9 R10 quiet during stray refill",
              64'({refill_req, fetch_hit}), 64'd0);
        #1 refill_valid = 1'b0;
        fetch(mk(9'd7, 6'd40, 3'd0), "R10 stray refill not stored");

        for (int p = 0; p < 8; p++)
            fetch(mk(9'd3, 6'd30, p[2:0]), "R3 R4 slot sweep");

        repeat (2) @(negedge clk);
        check(exp_instr_q.size() == 0, "R9 all fetches completed", 64'(exp_instr_q.size()), 64'd0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule